// File: doc/BRIEF.md
# Selectable-Length Synchronous Serial Port

This block is a clocked serial shift port for a small controller. Software loads a byte into the shift register, picks a transfer length of 4 or 8 bits, picks whether the port generates the serial clock itself or follows a clock supplied from outside, and then starts the transfer. Data leaves on the serial output most significant bit first. Data arrives on the serial input and is shifted into the low end of the register.

In internal mode the serial clock is built from a one-cycle instruction tick. It is low for a fixed number of ticks and then high for the same number. In external mode the incoming clock goes through a synchroniser, and its edges are detected in the system clock domain. When the last bit has been captured, the port raises a sticky completion flag, which software can poll. It also gives a one-cycle interrupt request. The port-select output tells the surrounding pin logic when the serial function owns the pins.

A controller state machine drives the port. Its states are `ST_IDLE`, `ST_INT_LOW`, `ST_INT_HIGH` and `ST_EXT_RUN`, with these transitions:
- `ST_IDLE` goes to `ST_INT_LOW` on an accepted start in internal mode, or to `ST_EXT_RUN` on an accepted start in external mode.
- `ST_INT_LOW` goes to `ST_INT_HIGH` when a half period ends, or back to `ST_IDLE` when that half period ends on the last bit.
- `ST_INT_HIGH` goes to `ST_INT_LOW` when a half period ends.
- `ST_EXT_RUN` goes to `ST_IDLE` on the external rising edge of the last bit.
- Every busy state returns to `ST_IDLE` when the enable is cleared.

Top module: `serlink_port`

## Requirements
- R1: The transfer length is taken from `cfg_len8` at start: 1 selects 8 bits and 0 selects 4 bits. A transfer ends after exactly that many serial-clock rising edges.
- R2: In internal mode `sck_out` is low for HALF_TICKS ticks of `cyc_tick` and then high for HALF_TICKS ticks, for each bit. It rests high whenever no transfer is running. `sck_oe` is 1 exactly when `cfg_en`=1 and `cfg_ext`=0.
- R3: `so` changes only at a serial-clock falling edge or at start. Bits leave most significant first: bit 7 first in 8-bit mode, and bit 3 first in 4-bit mode.
- R4: At each serial-clock rising edge, `si` is shifted into bit 0. In 4-bit mode only bits 3..0 shift, and bits 7..4 keep the loaded value.
- R5: When `cfg_ext`=1 the port follows `sck_in` through a two-stage synchroniser. It shifts out on the detected falling edges and in on the detected rising edges, and `sck_oe` stays 0.
- R6: On completion `done_flag` goes to 1 and `irq` pulses for exactly one cycle. The flag then holds until the next accepted start, which clears it.
- R7: While a transfer is running, writes through `wr_en` and further `start` pulses are ignored, and `rd_data` changes only by shifting.
- R8: After reset, and whenever `cfg_en`=0: `port_sel` is 0, `sck_out` is high, `so` is high after reset, `start` is ignored, and a running transfer is abandoned without setting `done_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-cycle instruction tick |
| cfg_en | input | 1 | Serial function enable |
| cfg_len8 | input | 1 | 1: 8-bit transfer, 0: 4-bit transfer |
| cfg_ext | input | 1 | 1: external serial clock, 0: internal |
| wr_en | input | 1 | Load `wr_data` into the shift register (idle only) |
| wr_data | input | 8 | Data to load |
| start | input | 1 | Start a transfer (idle and enabled only) |
| rd_data | output | 8 | Shift register contents |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion request |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| port_sel | output | 1 | Serial function owns the pins |

## Verification
The bench builds the port with HALF_TICKS set to 4, with WIDTH 8 and SHORT 4. A randomly gated tick then completes a full 8-bit internal transfer in a few hundred cycles. This makes it possible to run many random transfers in both lengths and both clock modes. The bench still counts every half period of the generated clock exactly. With the 8/4 split, the bench can check that the upper nibble survives a 4-bit transfer. It also covers an abandoned transfer, a start while disabled, and a write and start made in the middle of an externally clocked transfer.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_INT_LOW  = 2'd1,
        ST_INT_HIGH = 2'd2,
        ST_EXT_RUN  = 2'd3
    } sl_state_e;

endpackage

// File: rtl/serlink_edge.sv
module serlink_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/serlink_halfcnt.sv
module serlink_halfcnt #(
    parameter int HALF_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic half_done
);
    localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign half_done = run && tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_done) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/serlink_shreg.sv
module serlink_shreg #(
    parameter int WIDTH = 8,
    parameter int SHORT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] wdata,
    input  logic             shift,
    input  logic             short_mode,
    input  logic             sin,
    output logic [WIDTH-1:0] data,
    output logic             msb
);
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] full_next;
    logic [WIDTH-1:0] short_next;

    assign full_next = {data_q[WIDTH-2:0], sin};

    generate
        if (SHORT < WIDTH) begin : g_split
            assign short_next = {data_q[WIDTH-1:SHORT], data_q[SHORT-2:0], sin};
        end else begin : g_same
            assign short_next = full_next;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= wdata;
        end else if (shift) begin
            data_q <= short_mode ? short_next : full_next;
        end
    end

    assign data = data_q;
    assign msb  = short_mode ? data_q[SHORT-1] : data_q[WIDTH-1];
endmodule

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
    import serlink_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SHORT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic ext_sel,
    input  logic len8_sel,
    input  logic half_done,
    input  logic xrise,
    input  logic xfall,
    output logic busy,
    output logic go,
    output logic shift_en,
    output logic so_upd,
    output logic cnt_run,
    output logic len8_now,
    output logic sck_drv,
    output logic done_flag,
    output logic done_pulse
);
    localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [BW-1:0] LAST_FULL  = BW'(WIDTH - 1);
    localparam logic [BW-1:0] LAST_SHORT = BW'(SHORT - 1);

    sl_state_e      state_q, state_d;
    logic [BW-1:0]  bitcnt_q;
    logic           len8_q;
    logic           last_bit;
    logic           rise_ev;
    logic           fall_ev;

    assign last_bit = (bitcnt_q == (len8_q ? LAST_FULL : LAST_SHORT));
    assign go       = (state_q == ST_IDLE) && en && start;
    assign busy     = (state_q != ST_IDLE);
    assign cnt_run  = (state_q == ST_INT_LOW) || (state_q == ST_INT_HIGH);
    assign len8_now = go ? len8_sel : len8_q;

    assign rise_ev = en && (((state_q == ST_INT_LOW) && half_done) ||
                            ((state_q == ST_EXT_RUN) && xrise));
    assign fall_ev = go || (en && (((state_q == ST_INT_HIGH) && half_done) ||
                                   ((state_q == ST_EXT_RUN) && xfall)));
    assign shift_en = rise_ev;
    assign so_upd   = fall_ev;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ext_sel ? ST_EXT_RUN : ST_INT_LOW;
            end
            ST_INT_LOW: begin
                if (!en)            state_d = ST_IDLE;
                else if (half_done) state_d = last_bit ? ST_IDLE : ST_INT_HIGH;
            end
            ST_INT_HIGH: begin
                if (!en)            state_d = ST_IDLE;
                else if (half_done) state_d = ST_INT_LOW;
            end
            ST_EXT_RUN: begin
                if (!en)                    state_d = ST_IDLE;
                else if (xrise && last_bit) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            len8_q     <= 1'b1;
            done_flag  <= 1'b0;
            done_pulse <= 1'b0;
            sck_drv    <= 1'b1;
        end else begin
            sck_drv    <= (state_d != ST_INT_LOW);
            done_pulse <= rise_ev && last_bit;
            if (go) begin
                bitcnt_q  <= '0;
                len8_q    <= len8_sel;
                done_flag <= 1'b0;
            end else if (rise_ev) begin
                bitcnt_q <= bitcnt_q + 1'b1;
                if (last_bit) done_flag <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serlink_port.sv
module serlink_port #(
    parameter int WIDTH       = 8,
    parameter int SHORT       = 4,
    parameter int HALF_TICKS  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic             cfg_en,
    input  logic             cfg_len8,
    input  logic             cfg_ext,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             start,
    output logic [WIDTH-1:0] rd_data,
    output logic             done_flag,
    output logic             irq,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_oe,
    input  logic             si,
    output logic             so,
    output logic             port_sel
);
    logic busy, go, shift_en, so_upd, cnt_run, len8_now;
    logic half_done, xrise, xfall, msb;
    logic so_q;

    serlink_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .async_in(sck_in),
        .rise(xrise), .fall(xfall)
    );

    serlink_halfcnt #(.HALF_TICKS(HALF_TICKS)) u_half (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .tick(cyc_tick),
        .half_done(half_done)
    );

    serlink_ctrl #(.WIDTH(WIDTH), .SHORT(SHORT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .start(start),
        .ext_sel(cfg_ext), .len8_sel(cfg_len8), .half_done(half_done),
        .xrise(xrise), .xfall(xfall), .busy(busy), .go(go),
        .shift_en(shift_en), .so_upd(so_upd), .cnt_run(cnt_run),
        .len8_now(len8_now), .sck_drv(sck_out), .done_flag(done_flag),
        .done_pulse(irq)
    );

    serlink_shreg #(.WIDTH(WIDTH), .SHORT(SHORT)) u_shreg (
        .clk(clk), .rst_n(rst_n), .load(wr_en && !busy), .wdata(wr_data),
        .shift(shift_en), .short_mode(!len8_now), .sin(si),
        .data(rd_data), .msb(msb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      so_q <= 1'b1;
        else if (so_upd) so_q <= msb;
    end

    assign so       = so_q;
    assign sck_oe   = cfg_en && !cfg_ext;
    assign port_sel = cfg_en;
endmodule

// File: rtl/serlink_port_chk.sv
module serlink_port_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sck_out,
    input logic             busy,
    input logic             so,
    input logic             so_upd,
    input logic             shift_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             irq,
    input logic             done_flag,
    input logic             port_sel,
    input logic             go
);
    a_r2_sck_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_out |-> busy);

    a_r3_so_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !so_upd |=> $stable(so));

    a_r4_shift_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> busy);

    a_r6_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_flag);

    a_r6_start_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !done_flag);

    a_r7_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_en) |=> $stable(rd_data));

    a_r8_off_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |=> sck_out);
endmodule

bind serlink_port serlink_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck_out(sck_out), .busy(busy), .so(so),
    .so_upd(so_upd), .shift_en(shift_en), .rd_data(rd_data), .irq(irq),
    .done_flag(done_flag), .port_sel(port_sel), .go(go)
);

// File: tb/serlink_port_tb.sv
`timescale 1ns/1ps
module serlink_port_tb;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_tick = 1'b0;
    logic cfg_en = 1'b0, cfg_len8 = 1'b1, cfg_ext = 1'b0;
    logic wr_en = 1'b0, start = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic done_flag, irq, sck_out, sck_oe, so, port_sel;
    logic sck_in = 1'b1, si = 1'b0;

    int checks = 0, fails = 0, irq_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serlink_port #(.WIDTH(8), .SHORT(4), .HALF_TICKS(HALF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .cfg_en(cfg_en),
        .cfg_len8(cfg_len8), .cfg_ext(cfg_ext), .wr_en(wr_en), .wr_data(wr_data),
        .start(start), .rd_data(rd_data), .done_flag(done_flag), .irq(irq),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .si(si), .so(so),
        .port_sel(port_sel)
    );

    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc_tick = ($urandom % 3) == 0;
        end
    end

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input bit len8, input logic [7:0] tx,
                                          input logic [7:0] rx);
        return len8 ? rx : {tx[7:4], rx[3:0]};
    endfunction

    task automatic load(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic xfer_int(input bit len8, input logic [7:0] tx, input logic [7:0] rx);
        int n = len8 ? 8 : 4;
        int c;
        int irq0;
        load(tx);
        cfg_len8 = len8; cfg_ext = 1'b0; cfg_en = 1'b1;
        irq0 = irq_cnt;
        pulse_start();
        chk("R6 flag cleared by start", done_flag, 0);
        chk("R2 sck_oe internal", sck_oe, 1);
        for (int i = 0; i < n; i++) begin
            si = rx[n-1-i];
            c = 0;
            while (!sck_out) begin if (cyc_tick) c++; @(negedge clk); end
            chk("R2 low half ticks", c, HALF);
            chk("R3 so bit msb first", so, tx[n-1-i]);
            if (i < n - 1) begin
                c = 0;
                while (sck_out) begin if (cyc_tick) c++; @(negedge clk); end
                chk("R2 high half ticks", c, HALF);
            end
        end
        repeat (3) @(negedge clk);
        chk("R1 done after n bits", done_flag, 1);
        chk("R6 one irq pulse", irq_cnt - irq0, 1);
        chk("R4 received data", rd_data, exp_rd(len8, tx, rx));
        chk("R2 sck rests high", sck_out, 1);
    endtask

    task automatic xfer_ext(input bit len8, input logic [7:0] tx, input logic [7:0] rx,
                            input bit poke);
        int n = len8 ? 8 : 4;
        int irq0;
        load(tx);
        cfg_len8 = len8; cfg_ext = 1'b1; cfg_en = 1'b1;
        irq0 = irq_cnt;
        pulse_start();
        chk("R6 flag cleared by start", done_flag, 0);
        chk("R5 sck_oe external", sck_oe, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sck_in = 1'b0; si = rx[n-1-i];
            repeat (6) @(negedge clk);
            chk("R5 R3 so bit", so, tx[n-1-i]);
            if (poke && i == 1) begin
                wr_en = 1'b1; wr_data = ~tx; start = 1'b1;
                @(negedge clk); wr_en = 1'b0; start = 1'b0;
            end
            if (i < n - 1) chk("R1 not done early", done_flag, 0);
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk("R5 done", done_flag, 1);
        chk("R6 one irq pulse", irq_cnt - irq0, 1);
        chk("R7 R4 received data", rd_data, exp_rd(len8, tx, rx));
        chk("R5 sck_out idle", sck_out, 1);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset port_sel", port_sel, 0);
        chk("R8 reset sck_out", sck_out, 1);
        chk("R8 reset sck_oe", sck_oe, 0);
        chk("R8 reset done", done_flag, 0);
        chk("R8 reset so", so, 1);

        // start while disabled
        load(8'hA5);
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R8 start ignored sck", sck_out, 1);
        chk("R8 start ignored done", done_flag, 0);
        chk("R8 start ignored data", rd_data, 8'hA5);

        // directed corner cases
        xfer_int(1'b1, 8'h81, 8'h7E);
        chk("R6 flag holds", done_flag, 1);
        xfer_int(1'b0, 8'hC9, 8'h06);
        xfer_ext(1'b1, 8'h3C, 8'hD2, 1'b1);
        xfer_ext(1'b0, 8'h5A, 8'h0F, 1'b1);

        // abandon a running transfer
        load(8'hFF);
        cfg_len8 = 1'b1; cfg_ext = 1'b0; cfg_en = 1'b1;
        pulse_start();
        repeat (30) @(negedge clk);
        cfg_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 abort sck high", sck_out, 1);
        chk("R8 abort port_sel", port_sel, 0);
        chk("R8 abort no done", done_flag, 0);

        // random transfers
        for (int k = 0; k < 16; k++) begin
            logic [7:0] tx, rx;
            bit l8, ex;
            tx = 8'($urandom);
            rx = 8'($urandom);
            l8 = 1'($urandom);
            ex = 1'($urandom);
            if (ex) xfer_ext(l8, tx, rx, 1'($urandom));
            else    xfer_int(l8, tx, rx);
        end
        finish_up();
    end
endmodule